// File: doc/BRIEF.md
# I2C Target with Auto-Incrementing Register Pointer

This block is a two-wire serial target that gives a bus host access to a bank of 256 eight-bit registers. A faster system clock oversamples the clock and data lines and finds the bus conditions that open and close a transfer. The first byte after each opening condition holds a fixed 7-bit identity and a direction bit. A write then carries a register index byte, followed by any number of data bytes. Each data byte lands one register above the previous one.

To read, the host first writes the identity and an index, then issues a repeated opening condition and sends the identity with the read direction. The target then returns bytes starting at that index, and the index advances after each byte. The index steps from 255 back to 0. The data line is only ever pulled low, through an output-enable, and never driven high.

Top module: `i2c_regport`

## Requirements
- R1: After reset every register reads as 0x00 and the target releases SDA (sda_oe = 0).
- R2: A START (SDA falls while SCL is high) at any point, even in the middle of a byte, begins a new address byte. A STOP (SDA rises while SCL is high) returns the target to idle with SDA released.
- R3: The first byte after a START is the 7-bit device address (default 0x3C), MSB first, followed by the R/W bit (0 = write, 1 = read). On a match the target pulls SDA low for the whole ninth SCL clock.
- R4: On an address mismatch the target never pulls SDA low and stores nothing until the next START or STOP. The address byte and every later byte see SDA high in their ninth clock.
- R5: In a write, the byte after the address sets the register pointer and each later byte is stored at the pointer. Every byte of a matched write is acknowledged with SDA low in its ninth clock.
- R6: The pointer advances by one after each data byte written, so consecutive bytes fill consecutive registers.
- R7: The pointer steps from 0xFF to 0x00, for both writes and reads.
- R8: After a pointer-setting write, a repeated START and the address with R/W = 1, the target returns bytes MSB first from the pointer and advances the pointer after each byte. SDA stays released during the ninth clock, which the host drives (low = ACK, high = NACK).
- R9: After the host sends NACK, the target keeps SDA released on every further SCL clock until a STOP or START.
- R10: The target changes sda_oe only while SCL is low.
- R11: The pointer keeps its value across a STOP. A read that starts right after an address with R/W = 1 continues at the register after the last one transferred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Single-byte writes, bursts and a burst that crosses 0xFF are each read back through a repeated START. These cases separate the storing of data from the stepping of the pointer and from the wrap. A transfer sent to a foreign address shows whether the target stays silent and leaves the registers untouched. A host NACK followed by extra clocks shows whether the target lets go of the line. A read issued without a pointer write shows whether the pointer survives a STOP. A START in the middle of an address byte shows that a new transfer can cut into a partial one.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 1 << BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } bus_state_e;

  // identity compare on a received first byte (upper seven bits)
  function automatic logic addr_match(input logic [BYTE_W-1:0] first_byte,
                                      input logic [6:0] dev);
    return first_byte[BYTE_W-1:1] == dev;
  endfunction

  // pointer step, modulo the bank size
  function automatic logic [BYTE_W-1:0] ptr_next(input logic [BYTE_W-1:0] p);
    return p + {{(BYTE_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ptr,
  output bus_state_e        state
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              rw_bit, host_ack;
  logic              rx_phase;

  assign rx_phase = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rw_bit   <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      reg_we   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ptr      <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise && rx_phase) begin
          rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
          cnt   <= cnt + 1'b1;
        end
        if (scl_rise && state == ST_RACK) host_ack <= ~sda_s;
        if (scl_fall) begin
          unique case (state)
            ST_ADDR: if (cnt == FULL) begin
              if (addr_match(rx_sh, DEV_ADDR)) begin
                state  <= ST_ADDR_ACK;
                sda_oe <= 1'b1;
                rw_bit <= rx_sh[0];
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_ADDR_ACK: begin
              cnt <= '0;
              if (rw_bit) begin
                state  <= ST_RDATA;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                state  <= ST_PTR;
                sda_oe <= 1'b0;
              end
            end
            ST_PTR: if (cnt == FULL) begin
              ptr    <= rx_sh;
              state  <= ST_PTR_ACK;
              sda_oe <= 1'b1;
            end
            ST_PTR_ACK, ST_WDATA_ACK: begin
              state  <= ST_WDATA;
              cnt    <= '0;
              sda_oe <= 1'b0;
            end
            ST_WDATA: if (cnt == FULL) begin
              reg_we  <= 1'b1;
              wr_addr <= ptr;
              wr_data <= rx_sh;
              ptr     <= ptr_next(ptr);
              state   <= ST_WDATA_ACK;
              sda_oe  <= 1'b1;
            end
            ST_RDATA: begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
                ptr    <= ptr_next(ptr);
              end else begin
                tx_sh  <= tx_sh << 1;
                sda_oe <= ~tx_sh[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
            ST_RACK: begin
              if (host_ack) begin
                state  <= ST_RDATA;
                cnt    <= '0;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                state <= ST_IGNORE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  // named internal events, observed by the bound checker
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              reg_we;
  logic [BYTE_W-1:0] wr_addr, wr_data, ptr, rd_data;
  bus_state_e        state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .reg_we(reg_we), .wr_addr(wr_addr),
    .wr_data(wr_data), .ptr(ptr), .state(state)
  );

  i2c_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr), .rdata(rd_data)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
  import i2c_regport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              reg_we,
  input logic [BYTE_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] ptr,
  input bus_state_e        state
);
  // R10
  oe_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R2
  start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && state == ST_IDLE));

  // R4
  ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (ptr == BYTE_W'(wr_addr + 1'b1)));

  // R8
  host_ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK) |-> !sda_oe);
endmodule

bind i2c_regport i2c_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .reg_we(reg_we), .wr_addr(wr_addr),
  .ptr(ptr), .state(state)
);

// File: tb/tb_i2c_regport.sv
`timescale 1ns/1ps
module tb_i2c_regport;
  localparam int         Q   = 12;
  localparam logic [6:0] DEV = 7'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regport dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe));

  int n_chk = 0, n_bad = 0, hi_changes = 0;
  bit done = 0;
  logic [7:0] model [256];
  logic scl_d = 1'b1, oe_d = 1'b0;

  always @(negedge clk) begin
    if (rst_n && scl_m && scl_d && (sda_oe !== oe_d)) hi_changes++;
    scl_d <= scl_m;
    oe_d  <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_rstart;
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b1; wait_q(); wait_q();
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    sda_m = b; wait_q(); scl_m = 1'b1; wait_q(); r = sda_line; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 0; i < 8; i++) begin
      bit_xfer(1'b1, r);
      b = {b[6:0], r};
    end
    bit_xfer(~give_ack, r);
  endtask

  task automatic write_seq(input logic [7:0] p, input int n, input logic [7:0] seed);
    logic ack; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R3 write address ack", ack, 1);
    send_byte(p, ack);           chk("R5 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 29);
      send_byte(d, ack); chk("R5 data ack", ack, 1);
      model[8'(p + i)] = d;
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic [7:0] p, input int n, input string req);
    logic ack; logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R3 address ack", ack, 1);
    send_byte(p, ack);           chk("R5 pointer ack", ack, 1);
    bus_rstart();
    send_byte({DEV, 1'b1}, ack); chk("R8 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(req, b, model[8'(p + i)]);
    end
    bus_stop();
  endtask

  task automatic t_reset;
    chk("R1 sda released after reset", sda_oe, 0);
    read_seq(8'h00, 4, "R1 register reset value");
  endtask

  task automatic t_single;
    write_seq(8'h10, 1, 8'hA5);
    read_seq(8'h10, 1, "R5 single write readback");
  endtask

  task automatic t_burst;
    write_seq(8'h20, 4, 8'h3E);
    read_seq(8'h20, 4, "R6 burst consecutive registers");
  endtask

  task automatic t_wrap;
    write_seq(8'hFE, 3, 8'h71);
    read_seq(8'hFE, 3, "R7 wrap FF to 00");
  endtask

  task automatic t_mismatch;
    logic ack;
    bus_start();
    send_byte({7'h51, 1'b0}, ack); chk("R4 no ack on foreign address", ack, 0);
    send_byte(8'h10, ack);         chk("R4 silent on pointer byte", ack, 0);
    send_byte(8'h00, ack);         chk("R4 silent on data byte", ack, 0);
    bus_stop();
    read_seq(8'h10, 1, "R4 register untouched");
  endtask

  task automatic t_nack;
    logic ack, r; logic [7:0] b; int lows;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R3 address ack", ack, 1);
    send_byte(8'h10, ack);       chk("R5 pointer ack", ack, 1);
    bus_rstart();
    send_byte({DEV, 1'b1}, ack); chk("R8 read address ack", ack, 1);
    recv_byte(1'b0, b);          chk("R8 nacked byte value", b, model[8'h10]);
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      bit_xfer(1'b1, r);
      if (!r) lows++;
    end
    chk("R9 line stays released after NACK", lows, 0);
    bus_stop();
  endtask

  task automatic t_retain;
    logic ack; logic [7:0] b;
    read_seq(8'h20, 2, "R8 streamed read");
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("R11 direct read ack", ack, 1);
    recv_byte(1'b0, b);          chk("R11 pointer kept across STOP", b, model[8'h22]);
    bus_stop();
  endtask

  task automatic t_abort;
    logic ack, r; logic [7:0] a;
    a = {DEV, 1'b0};
    bus_start();
    for (int i = 7; i >= 4; i--) bit_xfer(a[i], r);
    bus_rstart();
    send_byte({DEV, 1'b0}, ack); chk("R2 address after mid-byte START", ack, 1);
    send_byte(8'h40, ack);       chk("R5 pointer ack", ack, 1);
    send_byte(8'hC3, ack);       chk("R5 data ack", ack, 1);
    model[8'h40] = 8'hC3;
    bus_stop();
    chk("R2 sda released after STOP", sda_oe, 0);
    read_seq(8'h40, 1, "R2 write after aborted byte");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_wrap();
    t_mismatch();
    t_nack();
    t_retain();
    t_abort();
    chk("R10 sda_oe changes while SCL high", hi_changes, 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule